// File: doc/BRIEF.md
# Block Erase Scheduler with Suspend

This block sequences the erasure of a list of storage blocks. A caller picks blocks one at a time with single-cycle select pulses. Each pick adds a bit to the pending mask and restarts a selection window. When the window expires without another pick, the scheduler launches. It drops every protected block from the list, and it erases the remaining blocks one after another, lowest index first. Each block is held for a duration that follows from its size. A whole-array request launches at once over all unprotected blocks and cannot be paused. If nothing is left to erase after protection is applied, the scheduler still reports a started operation, and it ends after a short fixed dwell.

Suspend and resume pulses pause the work. A suspend during the selection window freezes the list, and the matching resume launches immediately. A suspend during a block erase takes effect after a fixed latency. The erase progress is then frozen until resume, and the pair may be repeated. Every duration is counted in ticks of a time-base strobe.

The controller has seven states:
- IDLE: nothing pending.
- COLLECT: the selection window is open.
- HOLD: the window is suspended.
- ERASE: a block is being worked.
- QUIESCE: a suspend is waiting out its latency.
- PAUSED: the erase is suspended.
- VOID: the dwell of a request in which every block is protected.

Its transitions are:
- IDLE→COLLECT on a pick.
- IDLE→ERASE or IDLE→VOID on a whole-array request.
- COLLECT→COLLECT on a pick, which restarts the window.
- COLLECT→HOLD on suspend.
- COLLECT→ERASE or COLLECT→VOID on window expiry.
- HOLD→ERASE or HOLD→VOID on resume.
- ERASE→QUIESCE on suspend.
- ERASE→IDLE after the last block.
- QUIESCE→PAUSED when the latency expires.
- PAUSED→ERASE on resume.
- VOID→IDLE when the dwell ends.

Top module: `erase_sched`

## Requirements
- R1: After reset, busy, started, suspended, done and the pending mask are all zero.
- R2: In IDLE or COLLECT, a pick with an index below NUM_BLOCKS sets that bit in the pending mask and restarts a window of WINDOW_CYCLES ticks. The launch happens on the clock edge that follows a full window with no further pick. A pick with an index of NUM_BLOCKS or more is ignored.
- R3: All windows, durations and latencies advance only on cycles where tick is high. With tick held low, nothing expires.
- R4: At launch, protected blocks are removed from the pending mask without any error indication. The unprotected selected blocks are still erased.
- R5: Blocks are erased lowest index first, and each block occupies ERASE_UNIT_CYCLES×u+1 cycles. The size u is counted in 8 KB units: 2 for the boot block, 1 for each of the two parameter blocks, 4 for the 32 KB block and 8 for each 64 KB block. With TOP_BOOT=1, the boot block is at index NUM_BLOCKS-1, the parameter blocks are at the two indices below it and the 32 KB block is at the next index down. With TOP_BOOT=0 the order is mirrored from index 0. Done pulses high for exactly one cycle after the last block, and the block then returns to IDLE.
- R6: If nothing is left after protection is applied, started is raised with an empty mask. Done follows VOID_CYCLES+1 cycles after the launch.
- R7: Once started is high, picks and whole-array requests are ignored, so the pending mask never gains a bit.
- R8: A suspend in COLLECT raises suspended on the next cycle and stops the window. While suspended in this way, picks are ignored. A resume launches on its own edge.
- R9: A suspend during a block erase raises suspended SUSP_LAT+1 cycles later, and the erase progress stays frozen until resume. Suspend and resume can be repeated, and each pair delays done by the number of cycles from the suspend edge to the resume edge.
- R10: A whole-array request launches on its own edge over every unprotected block, and suspend has no effect on it.
- R11: A resume while nothing is suspended is ignored, and so is a second suspend while already suspended.
- R12: Busy is high in COLLECT, ERASE, QUIESCE and VOID. Started is high in ERASE, QUIESCE, PAUSED and VOID. Suspended is high in HOLD and PAUSED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe; counters advance when high |
| sel_valid | input | 1 | Single-cycle pick of a block |
| sel_idx | input | IDX_W | Index of the picked block |
| chip_req | input | 1 | Whole-array erase request |
| susp_req | input | 1 | Suspend pulse |
| resume_req | input | 1 | Resume pulse |
| protect | input | NUM_BLOCKS | Per-block protection, one bit per block |
| busy | output | 1 | Window open, erasing, suspend pending or dwell |
| started | output | 1 | Erase phase has begun |
| suspended | output | 1 | Window or erase is suspended |
| pending | output | NUM_BLOCKS | Blocks still to be erased |
| done | output | 1 | One-cycle pulse when the operation ends |

## Verification
The directed scenarios target the off-by-one points of the window. A pick made halfway through the window must push the launch out by a full window, so a design that fails to reload the counter would launch early. A design that did not strip protection at launch would show the wrong mask or the wrong total time. The all-protected case checks that started is still raised and that done arrives after the dwell, where a design that skipped the dwell would sit busy forever or finish at once. Suspend is tested in the window, in the middle of an erase, twice in a row, and against a whole-array erase. The exact cycle at which done arrives exposes any erase progress that leaks through a pause. It also exposes any suspend that was wrongly honoured on a whole-array erase.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HOLD,
        ST_ERASE,
        ST_QUIESCE,
        ST_PAUSED,
        ST_VOID
    } sched_state_e;

    // Size of block idx in 8 KB units; position 0 is the boot block end.
    function automatic int unsigned units_of(input int unsigned idx,
                                             input int unsigned nblk,
                                             input bit          top_boot);
        int unsigned pos;
        pos = top_boot ? (nblk - 1 - idx) : idx;
        if (pos == 0)      return 2;
        else if (pos < 3)  return 1;
        else if (pos == 3) return 4;
        return 8;
    endfunction

endpackage

// File: rtl/sched_timer.sv
module sched_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  count <= '0;
        else if (load)               count <= load_val;
        else if (en && count != '0)  count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(count));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> count == '0);

endmodule

// File: rtl/pick_next.sv
module pick_next #(
    parameter int N  = 19,
    parameter int IW = 5
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          found
);

    logic [N-1:0] first;

    for (genvar g = 0; g < N; g++) begin : g_first
        if (g == 0) begin : g_lo
            assign first[g] = mask[g];
        end else begin : g_hi
            assign first[g] = mask[g] & ~(|mask[g-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign found = |mask;

    // R5
    always_comb begin
        lowest_onehot_chk: assert ($onehot0(first));
    end

endmodule

// File: rtl/erase_sched.sv
module erase_sched
    import erase_sched_pkg::*;
#(
    parameter int NUM_BLOCKS        = 19,
    parameter int IDX_W             = $clog2(NUM_BLOCKS),
    parameter int WINDOW_CYCLES     = 20,
    parameter int ERASE_UNIT_CYCLES = 2,
    parameter int VOID_CYCLES       = 12,
    parameter int SUSP_LAT          = 3,
    parameter bit TOP_BOOT          = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  sel_valid,
    input  logic [IDX_W-1:0]      sel_idx,
    input  logic                  chip_req,
    input  logic                  susp_req,
    input  logic                  resume_req,
    input  logic [NUM_BLOCKS-1:0] protect,
    output logic                  busy,
    output logic                  started,
    output logic                  suspended,
    output logic [NUM_BLOCKS-1:0] pending,
    output logic                  done
);

    localparam int MAX_A = (WINDOW_CYCLES > 8 * ERASE_UNIT_CYCLES) ?
                           WINDOW_CYCLES : 8 * ERASE_UNIT_CYCLES;
    localparam int MAX_C = (MAX_A > VOID_CYCLES) ? MAX_A : VOID_CYCLES;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam int LW    = $clog2(SUSP_LAT + 2);

    localparam logic [CW-1:0]         WIN_V  = CW'(WINDOW_CYCLES);
    localparam logic [CW-1:0]         VOID_V = CW'(VOID_CYCLES);
    localparam logic [LW-1:0]         LAT_V  = LW'(SUSP_LAT);
    localparam logic [IDX_W:0]        NB_V   = (IDX_W + 1)'(NUM_BLOCKS);
    localparam logic [NUM_BLOCKS-1:0] ONE    = {{(NUM_BLOCKS-1){1'b0}}, 1'b1};
    localparam logic [NUM_BLOCKS-1:0] ALL    = {NUM_BLOCKS{1'b1}};

    sched_state_e state, nstate;

    logic                  chip_mode, chip_n;
    logic [NUM_BLOCKS-1:0] pend_n;
    logic                  done_n;
    logic                  do_launch;

    logic                  m_load, m_en, m_zero;
    logic [CW-1:0]         m_val, m_cnt;
    logic                  l_load, l_en, l_zero;
    logic [LW-1:0]         l_cnt;

    logic [CW-1:0]         dur_tab [NUM_BLOCKS];
    logic [IDX_W-1:0]      cur_idx, nxt_idx;
    logic                  cur_found, nxt_found;
    logic [NUM_BLOCKS-1:0] cur_oh, launch_mask, pick_src;
    logic                  sel_ok, blk_end;

    // Per-block erase time derived from the block size map.
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_dur
        localparam int unsigned CYC =
            ERASE_UNIT_CYCLES * units_of(g, NUM_BLOCKS, TOP_BOOT);
        assign dur_tab[g] = CW'(CYC);
    end

    assign sel_ok      = sel_valid && ({1'b0, sel_idx} < NB_V);
    assign cur_oh      = ONE << cur_idx;
    assign launch_mask = ((state == ST_IDLE) ? ALL : pending) & ~protect;
    assign pick_src    = (state == ST_ERASE) ? (pending & ~cur_oh) : launch_mask;
    assign blk_end     = (state == ST_ERASE) && m_zero;

    pick_next #(.N(NUM_BLOCKS), .IW(IDX_W)) u_cur (
        .mask  (pending),
        .idx   (cur_idx),
        .found (cur_found)
    );

    pick_next #(.N(NUM_BLOCKS), .IW(IDX_W)) u_nxt (
        .mask  (pick_src),
        .idx   (nxt_idx),
        .found (nxt_found)
    );

    assign m_en = tick && (state == ST_COLLECT || state == ST_ERASE ||
                           state == ST_VOID);
    assign l_en = tick && (state == ST_QUIESCE);

    sched_timer #(.W(CW)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (m_load),
        .load_val (m_val),
        .en       (m_en),
        .count    (m_cnt),
        .zero     (m_zero)
    );

    sched_timer #(.W(LW)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (l_load),
        .load_val (LAT_V),
        .en       (l_en),
        .count    (l_cnt),
        .zero     (l_zero)
    );

    // Next state and datapath control.
    always_comb begin
        nstate    = state;
        pend_n    = pending;
        chip_n    = chip_mode;
        done_n    = 1'b0;
        m_load    = 1'b0;
        m_val     = WIN_V;
        l_load    = 1'b0;
        do_launch = 1'b0;

        unique case (state)
            ST_IDLE: begin
                if (chip_req) begin
                    chip_n    = 1'b1;
                    do_launch = 1'b1;
                end else if (sel_ok) begin
                    chip_n = 1'b0;
                    pend_n = pending | (ONE << sel_idx);
                    m_load = 1'b1;
                    m_val  = WIN_V;
                    nstate = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (susp_req) begin
                    nstate = ST_HOLD;
                end else if (sel_ok) begin
                    pend_n = pending | (ONE << sel_idx);
                    m_load = 1'b1;
                    m_val  = WIN_V;
                end else if (m_zero) begin
                    do_launch = 1'b1;
                end
            end
            ST_HOLD: begin
                if (resume_req) do_launch = 1'b1;
            end
            ST_ERASE: begin
                if (blk_end) begin
                    pend_n = pending & ~cur_oh;
                    if (nxt_found) begin
                        m_load = 1'b1;
                        m_val  = dur_tab[nxt_idx];
                    end else begin
                        done_n = 1'b1;
                        chip_n = 1'b0;
                        nstate = ST_IDLE;
                    end
                end
                if (susp_req && !chip_mode && !(blk_end && !nxt_found)) begin
                    l_load = 1'b1;
                    nstate = ST_QUIESCE;
                end
            end
            ST_QUIESCE: begin
                if (l_zero) nstate = ST_PAUSED;
            end
            ST_PAUSED: begin
                if (resume_req) nstate = ST_ERASE;
            end
            ST_VOID: begin
                if (m_zero) begin
                    done_n = 1'b1;
                    chip_n = 1'b0;
                    nstate = ST_IDLE;
                end
            end
            default: nstate = ST_IDLE;
        endcase

        if (do_launch) begin
            pend_n = launch_mask;
            m_load = 1'b1;
            if (nxt_found) begin
                m_val  = dur_tab[nxt_idx];
                nstate = ST_ERASE;
            end else begin
                m_val  = VOID_V;
                nstate = ST_VOID;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pending   <= '0;
            chip_mode <= 1'b0;
            done      <= 1'b0;
        end else begin
            state     <= nstate;
            pending   <= pend_n;
            chip_mode <= chip_n;
            done      <= done_n;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        busy      = 1'b0;
        started   = 1'b0;
        suspended = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_COLLECT: busy = 1'b1;
            ST_HOLD:    suspended = 1'b1;
            ST_ERASE:   begin busy = 1'b1; started = 1'b1; end
            ST_QUIESCE: begin busy = 1'b1; started = 1'b1; end
            ST_PAUSED:  begin started = 1'b1; suspended = 1'b1; end
            ST_VOID:    begin busy = 1'b1; started = 1'b1; end
            default:    ;
        endcase
    end

    // R7
    no_late_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(started)) |-> ((pending & ~$past(pending)) == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pending == '0 && !started));

    // R5
    erase_has_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |-> cur_found);

    // R9
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUIESCE || state == ST_PAUSED) |=> $stable(m_cnt));

    // R9
    lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUIESCE) |-> (l_cnt <= LAT_V));

    // R8
    hold_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && resume_req) |=> started);

    // R10
    chip_nosusp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && chip_mode) |-> !suspended);

endmodule

// File: tb/erase_sched_test.sv
`timescale 1ns/1ps
module erase_sched_test;

    localparam int N     = 19;
    localparam int IW    = 5;
    localparam int WIN   = 20;
    localparam int UNIT  = 2;
    localparam int VOIDC = 12;
    localparam int LAT   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic          sel_valid = 1'b0;
    logic [IW-1:0] sel_idx = '0;
    logic          chip_req = 1'b0;
    logic          susp_req = 1'b0;
    logic          resume_req = 1'b0;
    logic [N-1:0]  protect = '0;
    logic          busy, started, suspended, done;
    logic [N-1:0]  pending;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    erase_sched #(
        .NUM_BLOCKS(N), .IDX_W(IW), .WINDOW_CYCLES(WIN),
        .ERASE_UNIT_CYCLES(UNIT), .VOID_CYCLES(VOIDC),
        .SUSP_LAT(LAT), .TOP_BOOT(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sel_valid(sel_valid),
        .sel_idx(sel_idx), .chip_req(chip_req), .susp_req(susp_req),
        .resume_req(resume_req), .protect(protect), .busy(busy),
        .started(started), .suspended(suspended), .pending(pending),
        .done(done)
    );

    function automatic int dur(input int i);
        int pos;
        int u;
        pos = N - 1 - i;
        if (pos == 0)      u = 2;
        else if (pos < 3)  u = 1;
        else if (pos == 3) u = 4;
        else               u = 8;
        return UNIT * u;
    endfunction

    function automatic logic [N-1:0] bit_of(input int i);
        return {{(N-1){1'b0}}, 1'b1} << i;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sel(input int idx, output int e);
        sel_valid = 1'b1;
        sel_idx   = IW'(idx);
        @(posedge clk);
        @(negedge clk);
        sel_valid = 1'b0;
        e = cyc;
    endtask

    task automatic pulse_chip(output int e);
        chip_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chip_req = 1'b0;
        e = cyc;
    endtask

    task automatic pulse_susp(output int e);
        susp_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        susp_req = 1'b0;
        e = cyc;
    endtask

    task automatic pulse_res(output int e);
        resume_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resume_req = 1'b0;
        e = cyc;
    endtask

    task automatic wait_done(output int e);
        e = -1;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done) begin
                e = cyc;
                break;
            end
        end
        idle_n(1);
    endtask

    task automatic t_reset;
        chk(busy == 0 && started == 0 && suspended == 0 && done == 0,
            "R1", "flags", {busy, started, suspended, done}, 0);
        chk(pending == '0, "R1", "pending", int'(pending), 0);
    endtask

    task automatic t_single;
        int e0, e;
        pulse_sel(16, e0);
        idle_n(WIN);
        chk(started == 0, "R2", "started before window end", started, 0);
        idle_n(1);
        chk(started == 1 && busy == 1, "R2", "started at window end", started, 1);
        chk(pending == bit_of(16), "R2", "pending", int'(pending), int'(bit_of(16)));
        wait_done(e);
        chk(e == e0 + WIN + 1 + dur(16) + 1, "R5", "done edge", e, e0 + WIN + 1 + dur(16) + 1);
        chk(done == 0 && busy == 0 && started == 0, "R5", "after done", {done, busy, started}, 0);
    endtask

    task automatic t_restart;
        int e0, e1, l, e;
        pulse_sel(0, e0);
        idle_n(10);
        pulse_sel(5, e1);
        chk(pending == (bit_of(0) | bit_of(5)), "R2", "two picks", int'(pending),
            int'(bit_of(0) | bit_of(5)));
        idle_n(WIN);
        chk(started == 0, "R2", "window restarted", started, 0);
        idle_n(1);
        l = cyc;
        chk(started == 1, "R2", "launch after restart", started, 1);
        idle_n(dur(0));
        chk(pending == (bit_of(0) | bit_of(5)), "R5", "first block busy", int'(pending),
            int'(bit_of(0) | bit_of(5)));
        idle_n(1);
        chk(pending == bit_of(5), "R5", "lowest index first", int'(pending), int'(bit_of(5)));
        wait_done(e);
        chk(e == l + dur(0) + 1 + dur(5) + 1, "R5", "two-block done", e, l + dur(0) + 1 + dur(5) + 1);
    endtask

    task automatic t_protect_skip;
        int ea, e1, e;
        protect = bit_of(3);
        pulse_sel(3, ea);
        pulse_sel(16, e1);
        idle_n(WIN + 1);
        chk(pending == bit_of(16), "R4", "protected dropped", int'(pending), int'(bit_of(16)));
        wait_done(e);
        chk(e == e1 + WIN + 1 + dur(16) + 1, "R4", "done edge", e, e1 + WIN + 1 + dur(16) + 1);
        protect = '0;
    endtask

    task automatic t_all_protected;
        int ea, e1, e;
        protect = bit_of(3) | bit_of(7);
        pulse_sel(3, ea);
        pulse_sel(7, e1);
        idle_n(WIN + 1);
        chk(started == 1 && busy == 1, "R6", "appears started", {started, busy}, 3);
        chk(pending == '0, "R6", "empty mask", int'(pending), 0);
        wait_done(e);
        chk(e == e1 + WIN + 1 + VOIDC + 1, "R6", "dwell done", e, e1 + WIN + 1 + VOIDC + 1);
        protect = '0;
    endtask

    task automatic t_no_add;
        int e0, ex, e;
        pulse_sel(1, e0);
        idle_n(WIN + 1);
        pulse_sel(2, ex);
        chk(pending == bit_of(1), "R7", "pick after start", int'(pending), int'(bit_of(1)));
        pulse_chip(ex);
        chk(pending == bit_of(1), "R7", "chip req after start", int'(pending), int'(bit_of(1)));
        wait_done(e);
        chk(e == e0 + WIN + 1 + dur(1) + 1, "R7", "done edge", e, e0 + WIN + 1 + dur(1) + 1);
    endtask

    task automatic t_window_susp;
        int e0, es, ex, er, e;
        pulse_sel(17, e0);
        idle_n(5);
        pulse_susp(es);
        chk(suspended == 1 && started == 0 && busy == 0, "R8", "held flags",
            {suspended, started, busy}, 4);
        pulse_susp(ex);
        chk(suspended == 1, "R11", "second suspend", suspended, 1);
        idle_n(2 * WIN);
        chk(started == 0, "R8", "window stopped", started, 0);
        pulse_sel(4, ex);
        chk(pending == bit_of(17), "R8", "pick while held", int'(pending), int'(bit_of(17)));
        pulse_res(er);
        chk(started == 1 && suspended == 0, "R8", "resume launches", {started, suspended}, 2);
        wait_done(e);
        chk(e == er + dur(17) + 1, "R8", "done edge", e, er + dur(17) + 1);
    endtask

    task automatic t_erase_susp;
        int ea, e1, l, ex, es, er, es2, er2, e, exp_e;
        pulse_sel(0, ea);
        pulse_sel(15, e1);
        l = e1 + WIN + 1;
        idle_n(WIN + 1 + 4);
        pulse_res(ex);
        chk(suspended == 0 && busy == 1, "R11", "stray resume", {suspended, busy}, 1);
        pulse_susp(es);
        idle_n(LAT);
        chk(suspended == 0 && busy == 1, "R9", "latency not yet over", suspended, 0);
        idle_n(1);
        chk(suspended == 1 && busy == 0 && started == 1, "R9", "suspended",
            {suspended, busy, started}, 5);
        pulse_susp(ex);
        idle_n(20);
        chk(suspended == 1, "R11", "suspend while suspended", suspended, 1);
        chk(pending == (bit_of(0) | bit_of(15)), "R9", "frozen mask", int'(pending),
            int'(bit_of(0) | bit_of(15)));
        pulse_res(er);
        chk(suspended == 0 && busy == 1, "R9", "resumed", {suspended, busy}, 1);
        idle_n(2);
        pulse_susp(es2);
        idle_n(LAT + 1);
        chk(suspended == 1, "R9", "second suspend", suspended, 1);
        pulse_res(er2);
        wait_done(e);
        exp_e = l + dur(0) + 1 + dur(15) + 1 + (er - es) + (er2 - es2);
        chk(e == exp_e, "R9", "done delayed by pauses", e, exp_e);
    endtask

    task automatic t_chip;
        int e0, ex, e;
        protect = ~(bit_of(16) | bit_of(17));
        pulse_chip(e0);
        chk(started == 1 && pending == (bit_of(16) | bit_of(17)), "R10", "chip launch",
            int'(pending), int'(bit_of(16) | bit_of(17)));
        pulse_susp(ex);
        idle_n(LAT + 1);
        chk(suspended == 0, "R10", "suspend ignored", suspended, 0);
        wait_done(e);
        chk(e == e0 + dur(16) + 1 + dur(17) + 1, "R10", "chip done", e, e0 + dur(16) + 1 + dur(17) + 1);
        protect = '1;
        pulse_chip(e0);
        chk(started == 1 && pending == '0, "R6", "chip all protected", int'(pending), 0);
        wait_done(e);
        chk(e == e0 + VOIDC + 1, "R6", "chip dwell done", e, e0 + VOIDC + 1);
        protect = '0;
    endtask

    task automatic t_tick;
        int e0, ts, e;
        tick = 1'b0;
        pulse_sel(16, e0);
        idle_n(3 * WIN);
        chk(started == 0 && busy == 1, "R3", "no tick no expiry", started, 0);
        ts = cyc;
        tick = 1'b1;
        wait_done(e);
        chk(e == ts + WIN + 1 + dur(16) + 1, "R3", "done after ticks", e, ts + WIN + 1 + dur(16) + 1);
    endtask

    task automatic t_range;
        int ex;
        pulse_sel(25, ex);
        idle_n(2);
        chk(busy == 0 && pending == '0, "R2", "out-of-range pick", int'(pending), 0);
        chk(started == 0 && suspended == 0, "R12", "idle flags", {started, suspended}, 0);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung got 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_restart();
        t_protect_skip();
        t_all_protected();
        t_no_add();
        t_window_susp();
        t_erase_susp();
        t_chip();
        t_tick();
        t_range();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule